// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between the issue stage of a SIMT core and the first-level data memory. It accepts one warp-wide load or store at a time: an activity mask with one bit per lane and one byte address per lane. Active lanes whose addresses land in the same 128-byte line are merged into a single line request. A warp that touches several lines produces one request per distinct line, one after another, over a valid/ready handshake.

Three free-running counters let software and performance studies judge how well accesses were merged. One counts instructions, one counts line requests, and one counts the cycles the issue side was held back while extra lines were being sent. The average number of requests per instruction is the ratio of the second counter to the first, and a value above one means the accesses were uncoalesced. A mode input lifts the issue hold. In that mode instructions are queued and released without waiting for their requests, so only the request stream carries the cost of poor coalescing.

Top module: `warp_coalescer`

## Requirements
- R1: Each request carries the line address, which is the byte address with bits [6:0] cleared. It also carries a lane mask with bit i set for exactly those still-active lanes whose address bits [31:7] match that line. An instruction that touches K distinct lines yields exactly K requests.
- R2: Requests of one instruction are issued in ascending order of the lowest-numbered lane that touches each line.
- R3: Lanes whose mask bit is 0 take no part in any request. An instruction with an all-zero mask produces no request and leaves in_ready high in the following cycle.
- R4: While req_valid is high and req_ready is low, req_valid, req_line and req_lanes hold their values.
- R5: With no_penalty low, once an instruction with K>0 lines is accepted, in_ready is low for exactly K+1 cycles when req_ready is held high. It rises only after the last request of that instruction has been accepted.
- R6: With no_penalty high, in_ready stays high while the internal instruction queue (4 entries) has space. Queued instructions still produce the same requests, in instruction order.
- R7: cnt_instr increases by one for every accepted instruction, including those with an empty mask.
- R8: cnt_reqs increases by one for every request accepted on the req handshake.
- R9: cnt_stall increases in each cycle where in_ready is low while a second or later line of an instruction is on the request port. An instruction of K lines sent with req_ready high adds K-1 in normal mode and 0 with no_penalty high.
- R10: After reset, in_ready is 1, req_valid is 0 and all three counters are 0.
- R11: For an instruction accepted at clock edge E, req_valid is still low in the cycle after E and goes high after edge E+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| no_penalty | input | 1 | 1 = release the issue side without waiting for line requests |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be accepted |
| in_mask | input | 32 | Lane activity mask, bit i = lane i |
| in_addr | input | 1024 | Lane byte addresses, lane i at bits [32*i+31:32*i] |
| req_valid | output | 1 | Line request present |
| req_ready | input | 1 | Downstream accepts the request |
| req_line | output | 32 | Line-aligned byte address |
| req_lanes | output | 32 | Lanes served by this request |
| cnt_instr | output | 32 | Instructions accepted |
| cnt_reqs | output | 32 | Line requests accepted |
| cnt_stall | output | 32 | Issue cycles lost to extra lines |

## Verification
An instruction accepted at one edge enters the queue. It reaches the line engine at the next edge, so its first request appears two edges after acceptance. Each further line follows one edge after the previous one is taken, and the counters move on the same edge as the event they count. The bench drives on the falling edge and samples 4 ns later, just before the next rising edge. It walks the acceptance cycle sample by sample, checking req_valid low in the first window and high in the second. It counts the windows with in_ready low and reads the counters only once in_ready has risen again. Expected requests come from a bench-side grouping of the lane addresses by bits [31:7], ordered by lowest lane.

// File: rtl/coal_pkg.sv
`timescale 1ns/1ps
package coal_pkg;
  localparam int unsigned DEF_LANES      = 32;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_LINE_BYTES = 128;
  localparam int unsigned DEF_QDEPTH     = 4;
  localparam int unsigned DEF_CNT_W      = 32;

  // Issue-side policy selected by the no_penalty input
  typedef enum logic [0:0] {
    ISSUE_HOLD = 1'b0,
    ISSUE_FREE = 1'b1
  } issue_mode_e;
endpackage

// File: rtl/coal_queue.sv
`timescale 1ns/1ps
// Instruction queue: DEPTH must be a power of two.
module coal_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rptr];
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/coal_match.sv
`timescale 1ns/1ps
// Picks the lowest pending lane and gathers every pending lane on its line.
module coal_match #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*ADDR_W-1:0] addrs,
  output logic                    any,
  output logic [ADDR_W-OFF_W-1:0] lead_line,
  output logic [LANES-1:0]        match
);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(LANES);

  logic [IDX_W-1:0] lead_idx;

  always_comb begin
    lead_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) lead_idx = IDX_W'(i);
    end
  end

  assign lead_line = addrs[int'(lead_idx)*ADDR_W + OFF_W +: LINE_W];
  assign any       = |pending;

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign match[g] = pending[g] &&
                      (addrs[g*ADDR_W + OFF_W +: LINE_W] == lead_line);
  end

  // R2: the lowest pending lane is always part of the request being shown
  assert_lead_lane_R2: assert property (@(posedge clk) disable iff (rst)
    any |-> ((match & (pending & (~pending + 1'b1))) != '0));
endmodule

// File: rtl/coal_counters.sv
`timescale 1ns/1ps
module coal_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_instr,
  input  logic             inc_req,
  input  logic             inc_stall,
  output logic [CNT_W-1:0] cnt_instr,
  output logic [CNT_W-1:0] cnt_reqs,
  output logic [CNT_W-1:0] cnt_stall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_instr <= '0;
      cnt_reqs  <= '0;
      cnt_stall <= '0;
    end else begin
      if (inc_instr) cnt_instr <= cnt_instr + 1'b1;
      if (inc_req)   cnt_reqs  <= cnt_reqs + 1'b1;
      if (inc_stall) cnt_stall <= cnt_stall + 1'b1;
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
`timescale 1ns/1ps
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES      = DEF_LANES,
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int LINE_BYTES = DEF_LINE_BYTES,
  parameter int QDEPTH     = DEF_QDEPTH,
  parameter int CNT_W      = DEF_CNT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    no_penalty,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES-1:0]        in_mask,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [ADDR_W-1:0]       req_line,
  output logic [LANES-1:0]        req_lanes,
  output logic [CNT_W-1:0]        cnt_instr,
  output logic [CNT_W-1:0]        cnt_reqs,
  output logic [CNT_W-1:0]        cnt_stall
);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int LINE_W  = ADDR_W - OFF_W;
  localparam int AFLAT_W = LANES * ADDR_W;
  localparam int ENTRY_W = LANES + AFLAT_W;

  issue_mode_e mode;
  assign mode = no_penalty ? ISSUE_FREE : ISSUE_HOLD;

  // Instruction queue
  logic               in_fire, q_wr, q_rd, q_empty, q_full;
  logic [ENTRY_W-1:0] q_rdata;
  logic [LANES-1:0]   q_mask;
  logic [AFLAT_W-1:0] q_addr;

  assign in_fire = in_valid && in_ready;
  assign q_wr    = in_fire && (in_mask != '0);   // empty masks retire at once
  assign q_mask  = q_rdata[ENTRY_W-1 -: LANES];
  assign q_addr  = q_rdata[AFLAT_W-1:0];

  coal_queue #(.W(ENTRY_W), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .wr_en(q_wr), .wr_data({in_mask, in_addr}),
    .rd_en(q_rd), .rd_data(q_rdata),
    .empty(q_empty), .full(q_full)
  );

  // Line engine state
  logic [LANES-1:0]   pending;
  logic [AFLAT_W-1:0] cur_addr;
  logic               first;
  logic [LANES-1:0]   match, remain;
  logic [LINE_W-1:0]  lead_line;
  logic               any, req_fire, load;

  coal_match #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
    .clk(clk), .rst(rst),
    .pending(pending), .addrs(cur_addr),
    .any(any), .lead_line(lead_line), .match(match)
  );

  assign req_valid = any;
  assign req_line  = {lead_line, {OFF_W{1'b0}}};
  assign req_lanes = match;
  assign req_fire  = req_valid && req_ready;
  assign remain    = pending & ~(req_fire ? match : '0);
  assign load      = !q_empty && (remain == '0);
  assign q_rd      = load;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      first   <= 1'b0;
    end else if (load) begin
      pending <= q_mask;
      first   <= 1'b1;
    end else if (req_fire) begin
      pending <= remain;
      first   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) cur_addr <= q_addr;
  end

  // Issue handshake policy
  always_comb begin
    if (mode == ISSUE_FREE) in_ready = !q_full;
    else                    in_ready = q_empty && (pending == '0);
  end

  coal_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .inc_instr(in_fire),
    .inc_req(req_fire),
    .inc_stall(!in_ready && req_valid && !first),
    .cnt_instr(cnt_instr), .cnt_reqs(cnt_reqs), .cnt_stall(cnt_stall)
  );

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_line) && $stable(req_lanes)));

  assert_block_issue_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == ISSUE_HOLD && req_valid) |-> !in_ready);

  assert_lanes_retire_R1: assert property (@(posedge clk) disable iff (rst)
    (req_fire && !load) |=> ((pending & $past(req_lanes)) == '0));
endmodule

// File: tb/warp_coalescer_test.sv
`timescale 1ns/1ps
module warp_coalescer_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         no_penalty = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_mask = '0;
  logic [1023:0] in_addr = '0;
  logic         req_valid;
  logic         req_ready = 1'b1;
  logic [31:0]  req_line, req_lanes;
  logic [31:0]  cnt_instr, cnt_reqs, cnt_stall;

  always #5 clk = ~clk;

  warp_coalescer uut (
    .clk(clk), .rst(rst), .no_penalty(no_penalty),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_addr(in_addr),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_lanes(req_lanes),
    .cnt_instr(cnt_instr), .cnt_reqs(cnt_reqs), .cnt_stall(cnt_stall)
  );

  int n_run = 0, n_fail = 0;
  logic [31:0] lane_a [32];
  logic [31:0] cap_line [64], cap_lanes [64];
  logic [31:0] exp_line [64], exp_lanes [64];
  int cap_n = 0, exp_n = 0, waited = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // request monitor, 1 ns before each rising edge
  always begin
    @(negedge clk); #4;
    if (!rst && req_valid && req_ready && cap_n < 64) begin
      cap_line[cap_n]  = req_line;
      cap_lanes[cap_n] = req_lanes;
      cap_n++;
    end
  end

  // expected grouping: 128-byte lines, ordered by lowest lane
  task automatic build_expect(input logic [31:0] mask);
    logic [31:0] pend, m;
    logic [24:0] ln;
    pend = mask;
    while (pend != 0) begin
      int lead = 0;
      for (int i = 31; i >= 0; i--) if (pend[i]) lead = i;
      ln = lane_a[lead][31:7];
      m = '0;
      for (int j = 0; j < 32; j++) if (pend[j] && lane_a[j][31:7] == ln) m[j] = 1'b1;
      exp_line[exp_n]  = {ln, 7'b0};
      exp_lanes[exp_n] = m;
      exp_n++;
      pend = pend & ~m;
    end
  endtask

  task automatic issue(input logic [31:0] mask);
    @(negedge clk);
    in_mask = mask;
    for (int i = 0; i < 32; i++) in_addr[i*32 +: 32] = lane_a[i];
    in_valid = 1'b1;
    waited = 0;
    #4;
    while (!in_ready) begin waited++; @(negedge clk); #4; end
    @(negedge clk);
    in_valid = 1'b0;
    in_mask = '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int c = 0; c < 400 && quiet < 2; c++) begin
      @(negedge clk); #4;
      if (!req_valid && in_ready) quiet++; else quiet = 0;
    end
  endtask

  task automatic compare(input string tag);
    check(cap_n == exp_n, {tag, " request count"}, cap_n, exp_n);
    for (int k = 0; k < exp_n && k < cap_n; k++) begin
      check(cap_line[k] == exp_line[k], {tag, " line"}, cap_line[k], exp_line[k]);
      check(cap_lanes[k] == exp_lanes[k], {tag, " lanes"}, cap_lanes[k], exp_lanes[k]);
    end
  endtask

  // normal mode, req_ready high: timing, hold length, counters
  task automatic run_normal(input logic [31:0] mask, input string tag);
    logic [31:0] s0, i0, r0;
    int low = 0, lexp;
    s0 = cnt_stall; i0 = cnt_instr; r0 = cnt_reqs;
    cap_n = 0; exp_n = 0;
    build_expect(mask);
    issue(mask);
    for (int c = 0; c < 200; c++) begin
      #4;
      if (c == 0) check(!req_valid, {tag, " R11 no request right after accept"}, req_valid, 0);
      if (c == 1) check(req_valid == 1'b1, {tag, " R11 request after second edge"}, req_valid, 1);
      if (in_ready) break;
      low++;
      @(negedge clk);
    end
    lexp = (exp_n == 0) ? 0 : exp_n + 1;
    check(low == lexp, {tag, " R5 in_ready low cycles"}, low, lexp);
    compare({tag, " R1 R2"});
    check(cnt_instr == i0 + 1, {tag, " R7 instr count"}, cnt_instr, i0 + 1);
    check(cnt_reqs == r0 + exp_n, {tag, " R8 request count"}, cnt_reqs, r0 + exp_n);
    check(cnt_stall == s0 + ((exp_n > 0) ? exp_n - 1 : 0), {tag, " R9 stall count"},
          cnt_stall, s0 + ((exp_n > 0) ? exp_n - 1 : 0));
  endtask

  task automatic t_reset();
    #4;
    check(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
    check(req_valid == 1'b0, "R10 req_valid after reset", req_valid, 0);
    check(cnt_instr == 0 && cnt_reqs == 0 && cnt_stall == 0, "R10 counters after reset",
          {cnt_instr, cnt_reqs}, 0);
  endtask

  task automatic t_one_line();
    for (int i = 0; i < 32; i++) lane_a[i] = 32'h1000_0000 + i * 4;
    run_normal(32'hFFFF_FFFF, "one line");
    check(cap_lanes[0] == 32'hFFFF_FFFF, "R1 full merge mask", cap_lanes[0], 32'hFFFF_FFFF);
  endtask

  task automatic t_interleaved();
    for (int i = 0; i < 32; i++) lane_a[i] = 32'h1800_0000 + ((i * 3) % 4) * 128 + (i * 4) % 128;
    run_normal(32'hFFFF_FFFF, "interleaved");
    check(cap_line[1] == 32'h1800_0180, "R2 second line follows lane 1", cap_line[1], 32'h1800_0180);
  endtask

  task automatic t_scatter();
    for (int i = 0; i < 32; i++) lane_a[i] = 32'h2400_0000 + (31 - i) * 128 + 5;
    run_normal(32'hFFFF_FFFF, "scatter");
  endtask

  task automatic t_partial();
    for (int i = 0; i < 32; i++) lane_a[i] = 32'h3000_0000 + i * 128;
    lane_a[0] = 32'h2000_007F;
    lane_a[1] = 32'h2000_0080;
    lane_a[2] = 32'h2000_0000;
    run_normal(32'h0000_0007, "partial R3");
    check(cap_lanes[0] == 32'h5, "R3 inactive lanes excluded", cap_lanes[0], 32'h5);
    check(cap_line[1] == 32'h2000_0080, "R1 line boundary at 0x80", cap_line[1], 32'h2000_0080);
  endtask

  task automatic t_empty();
    run_normal(32'h0, "empty R3");
    check(cap_n == 0, "R3 empty mask no request", cap_n, 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] l0, m0;
    for (int i = 0; i < 32; i++) lane_a[i] = 32'h5000_0000 + (i % 4) * 128;
    cap_n = 0; exp_n = 0;
    build_expect(32'hFFFF_FFFF);
    @(negedge clk); req_ready = 1'b0;
    issue(32'hFFFF_FFFF);
    @(negedge clk); #4;
    l0 = req_line; m0 = req_lanes;
    check(req_valid && l0 == exp_line[0], "R4 first request shown", l0, exp_line[0]);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #4;
      check(req_valid && req_line == l0 && req_lanes == m0, "R4 held under backpressure",
            {req_line, req_lanes}, {l0, m0});
      check(!in_ready, "R5 issue held while lines pending", in_ready, 0);
    end
    @(negedge clk); req_ready = 1'b1;
    wait_idle();
    compare("R4 after release");
  endtask

  task automatic t_no_penalty();
    logic [31:0] s0;
    s0 = cnt_stall;
    cap_n = 0; exp_n = 0;
    no_penalty = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 32; i++) lane_a[i] = 32'h4000_0000 + k * 32'h1000 + (i % 2) * 128;
      build_expect(32'hFFFF_FFFF);
      issue(32'hFFFF_FFFF);
      check(waited == 0, "R6 accepted without waiting", waited, 0);
    end
    @(negedge clk); req_ready = 1'b1;
    wait_idle();
    compare("R6 queued requests");
    check(cnt_stall == s0, "R9 no stall in no-penalty mode", cnt_stall, s0);
    no_penalty = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog R5 run did not complete actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) lane_a[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_one_line();
    t_interleaved();
    t_scatter();
    t_partial();
    t_empty();
    t_backpressure();
    t_no_penalty();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule